// File: doc/BRIEF.md
# Dual-Tap Line Reversal and Merge

This block sits behind the two digitisers of a split-register area sensor. The sensor can drive its two output taps at once, one sample per pixel clock each. The left tap carries the left half of every row in spatial order. The right tap carries the right half mirrored, so its outermost pixel comes first. The block keeps only the image pixels of each half and turns the right half back into left-to-right order. It emits one continuous row on a single output stream, marked with a valid strobe and a start-of-row flag.

Each tap's row opens with a run of non-image samples: empty register cells, light-shielded reference pixels and one outer edge band of buffer pixels. Then come the tap's image pixels. In dual mode both halves of a row are stored in one bank of a two-bank memory. The right half is written at mirrored addresses. When the row is complete, that bank is read out in a single burst at one pixel per core clock, while the next row fills the other bank. In single mode only the left tap carries the whole row, already in order. The block then forwards the image pixels straight through and ignores the right tap.

The core clock runs at least twice the pixel rate, so a pixel pair is presented at most every other core cycle. A row that is cut short by a new start-of-row raises a one-cycle error pulse.

Top module: `dual_tap_stitch`

## Requirements
- R1: While and directly after reset, `outValid`, `outStart` and `lineErr` are low.
- R2: In dual mode each complete row produces exactly 2*HALF_ACT output pixels on consecutive core cycles. The first HALF_ACT are the left-tap image pixels in arrival order. The next HALF_ACT are the right-tap image pixels in reverse arrival order.
- R3: Per tap, counting the start-of-row sample as index 0, the image pixels are indices PRE to PRE+HALF_ACT-1, where PRE = EMPTY_PIX+SHIELD_PIX+EDGE_BUF. No sample at any other index ever reaches `outPix`.
- R4: In dual mode the first output pixel of a row is visible two core-clock edges after the edge that captures the row's last input sample. `outStart` is high with that first pixel only.
- R5: Rows presented back to back at the full pixel rate (one sample pair every second core cycle) are each output complete and correct. A row's readout overlaps the capture of the next row.
- R6: In single mode the row is EMPTY_PIX+SHIELD_PIX+2*EDGE_BUF+2*HALF_ACT+SHIELD_PIX samples long. Left-tap indices PRE to PRE+2*HALF_ACT-1 are output in order, each one edge after its capture. The right tap has no effect.
- R7: In single mode `outStart` marks the pixel taken from index PRE and no other.
- R8: A start-of-row that arrives before the current row has reached its full sample count gives a one-cycle `lineErr` pulse one edge later. In dual mode the truncated row produces no output.
- R9: Samples presented with `pixValid` high after a row is complete and before the next start-of-row produce no output and no error.
- R10: While `pixValid` is low, `lineStart`, `leftPix` and `rightPix` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, at least twice the pixel rate |
| rstN | input | 1 | Asynchronous active-low reset |
| dualMode | input | 1 | 1 = both taps used, 0 = left tap carries the full row; held static |
| pixValid | input | 1 | A sample pair is present this cycle |
| lineStart | input | 1 | With `pixValid`, this sample is index 0 of a new row |
| leftPix | input | DW | Left-tap sample |
| rightPix | input | DW | Right-tap sample (mirrored order) |
| outValid | output | 1 | `outPix` holds an image pixel |
| outStart | output | 1 | First pixel of an output row |
| outPix | output | DW | Output image pixel |
| lineErr | output | 1 | One-cycle pulse: row was cut short |

## Verification
In dual mode a row's first pixel is due two edges after the edge that captures its last sample. The rest of the row follows on each later cycle. In single mode each image pixel and each error pulse are due one edge after the capturing edge. The bench records the core-cycle count when it drives each relevant sample and when the monitor sees each output on a falling edge. It then compares those counts with these offsets and checks that pixels inside a row sit on consecutive cycles. Pixel values encode row number, tap and stream index, so every output is compared against the value the index rules predict.

// File: rtl/tap_stitch_pkg.sv
package tap_stitch_pkg;
  // Strobes from the control to the datapath, valid in the current cycle.
  typedef struct packed {
    logic wrEn;     // store the current sample pair in the fill bank
    logic wrBank;   // bank being filled
    logic rdEn;     // burst readout active
    logic rdBank;   // bank being drained
    logic passEn;   // single mode: forward the left sample
    logic firstPix; // current sample is the first image pixel of its row
  } stitchCtl_t;
endpackage

// File: rtl/tap_stitch_ctrl.sv
module tap_stitch_ctrl
  import tap_stitch_pkg::*;
#(
  parameter int EMPTY_PIX  = 4,
  parameter int SHIELD_PIX = 28,
  parameter int EDGE_BUF   = 4,
  parameter int HALF_ACT   = 960,
  localparam int PRE        = EMPTY_PIX + SHIELD_PIX + EDGE_BUF,
  localparam int DUAL_LEN   = PRE + HALF_ACT,
  localparam int SINGLE_LEN = PRE + 2 * HALF_ACT + EDGE_BUF + SHIELD_PIX,
  localparam int CNT_W      = $clog2(SINGLE_LEN + 1),
  localparam int AW         = $clog2(HALF_ACT),
  localparam int RD_W       = $clog2(2 * HALF_ACT)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            dualMode,
  input  logic            pixValid,
  input  logic            lineStart,
  output stitchCtl_t      ctl,
  output logic [AW-1:0]   wrIdx,
  output logic [RD_W-1:0] rdIdx,
  output logic            lineErr
);
  localparam logic [CNT_W-1:0] PRE_C    = CNT_W'(PRE);
  localparam logic [CNT_W-1:0] END_D    = CNT_W'(PRE + HALF_ACT);
  localparam logic [CNT_W-1:0] END_S    = CNT_W'(PRE + 2 * HALF_ACT);
  localparam logic [CNT_W-1:0] LEN_D    = CNT_W'(DUAL_LEN);
  localparam logic [CNT_W-1:0] LEN_S    = CNT_W'(SINGLE_LEN);
  localparam logic [RD_W-1:0]  LAST_RD  = RD_W'(2 * HALF_ACT - 1);

  logic             inLine, accept, act, lastPix;
  logic [CNT_W-1:0] pixCnt, curIdx, nextIdx, lineLen, actEnd;
  logic             wrBank, rdBank, rdActive;

  always_comb begin
    curIdx  = lineStart ? '0 : pixCnt;
    nextIdx = curIdx + CNT_W'(1);
    lineLen = dualMode ? LEN_D : LEN_S;
    actEnd  = dualMode ? END_D : END_S;
    accept  = pixValid && (lineStart || inLine);
    act     = accept && (curIdx >= PRE_C) && (curIdx < actEnd);
    lastPix = accept && (nextIdx == lineLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inLine   <= 1'b0;
      pixCnt   <= '0;
      lineErr  <= 1'b0;
      wrBank   <= 1'b0;
      rdBank   <= 1'b0;
      rdActive <= 1'b0;
      rdIdx    <= '0;
    end else begin
      lineErr <= pixValid && lineStart && inLine;
      if (accept) begin
        pixCnt <= nextIdx;
        inLine <= (nextIdx != lineLen);
      end
      if (lastPix && dualMode) begin
        wrBank   <= ~wrBank;
        rdBank   <= wrBank;
        rdActive <= 1'b1;
        rdIdx    <= '0;
      end else if (rdActive) begin
        rdIdx <= rdIdx + RD_W'(1);
        if (rdIdx == LAST_RD) rdActive <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.wrEn     = act && dualMode;
    ctl.wrBank   = wrBank;
    ctl.rdEn     = rdActive;
    ctl.rdBank   = rdBank;
    ctl.passEn   = act && !dualMode;
    ctl.firstPix = (curIdx == PRE_C);
    wrIdx        = AW'(curIdx - PRE_C);
  end
endmodule

// File: rtl/tap_stitch_datapath.sv
module tap_stitch_datapath
  import tap_stitch_pkg::*;
#(
  parameter int DW       = 12,
  parameter int HALF_ACT = 960,
  localparam int AW      = $clog2(HALF_ACT),
  localparam int RD_W    = $clog2(2 * HALF_ACT),
  localparam int DEPTH   = 2 * HALF_ACT
) (
  input  logic            clk,
  input  logic            rstN,
  input  stitchCtl_t      ctl,
  input  logic [AW-1:0]   wrIdx,
  input  logic [RD_W-1:0] rdIdx,
  input  logic [DW-1:0]   leftPix,
  input  logic [DW-1:0]   rightPix,
  output logic            outValid,
  output logic            outStart,
  output logic [DW-1:0]   outPix
);
  localparam logic [RD_W-1:0] HALF_C = RD_W'(HALF_ACT);
  localparam logic [RD_W-1:0] TOP_C  = RD_W'(HALF_ACT - 1);

  logic [DW-1:0]   leftMem  [DEPTH];
  logic [DW-1:0]   rightMem [DEPTH];
  logic [RD_W-1:0] wrBase, rdBase, wrAddrL, wrAddrR, rdAddr;
  logic            rdRight;
  logic [DW-1:0]   rdData;

  always_comb begin
    wrBase  = ctl.wrBank ? HALF_C : '0;
    rdBase  = ctl.rdBank ? HALF_C : '0;
    wrAddrL = wrBase + RD_W'(wrIdx);
    // mirrored arrival: first right sample is the rightmost pixel
    wrAddrR = wrBase + (TOP_C - RD_W'(wrIdx));
    rdRight = (rdIdx >= HALF_C);
    rdAddr  = rdBase + (rdRight ? (rdIdx - HALF_C) : rdIdx);
    rdData  = rdRight ? rightMem[rdAddr] : leftMem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (ctl.wrEn) begin
      leftMem[wrAddrL]  <= leftPix;
      rightMem[wrAddrR] <= rightPix;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outStart <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= ctl.rdEn || ctl.passEn;
      outStart <= (ctl.rdEn && rdIdx == '0) || (ctl.passEn && ctl.firstPix);
      if (ctl.rdEn)        outPix <= rdData;
      else if (ctl.passEn) outPix <= leftPix;
    end
  end
endmodule

// File: rtl/dual_tap_stitch.sv
module dual_tap_stitch
  import tap_stitch_pkg::*;
#(
  parameter int DW         = 12,
  parameter int EMPTY_PIX  = 4,
  parameter int SHIELD_PIX = 28,
  parameter int EDGE_BUF   = 4,
  parameter int HALF_ACT   = 960
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dualMode,
  input  logic          pixValid,
  input  logic          lineStart,
  input  logic [DW-1:0] leftPix,
  input  logic [DW-1:0] rightPix,
  output logic          outValid,
  output logic          outStart,
  output logic [DW-1:0] outPix,
  output logic          lineErr
);
  localparam int AW   = $clog2(HALF_ACT);
  localparam int RD_W = $clog2(2 * HALF_ACT);

  stitchCtl_t      ctl;
  logic [AW-1:0]   wrIdx;
  logic [RD_W-1:0] rdIdx;

  tap_stitch_ctrl #(
    .EMPTY_PIX(EMPTY_PIX), .SHIELD_PIX(SHIELD_PIX),
    .EDGE_BUF(EDGE_BUF), .HALF_ACT(HALF_ACT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .dualMode(dualMode), .pixValid(pixValid),
    .lineStart(lineStart), .ctl(ctl), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .lineErr(lineErr)
  );

  tap_stitch_datapath #(.DW(DW), .HALF_ACT(HALF_ACT)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .leftPix(leftPix), .rightPix(rightPix),
    .outValid(outValid), .outStart(outStart), .outPix(outPix)
  );
endmodule

// File: rtl/tap_stitch_checker.sv
module tap_stitch_checker (
  input logic clk,
  input logic rstN,
  input logic dualMode,
  input logic pixValid,
  input logic lineStart,
  input logic outValid,
  input logic outStart,
  input logic lineErr
);
  // R2/R4: a start flag only ever accompanies a valid pixel
  assert_start_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    outStart |-> outValid);

  // R2: within a dual-mode row, output pixels are on back-to-back cycles
  assert_dual_burst_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dualMode && outValid && !outStart) |-> $past(outValid));

  // R8: an error pulse follows a start-of-row sample
  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    lineErr |-> $past(pixValid && lineStart));

  // R6/R10: single-mode output only follows an accepted input sample
  assert_single_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!dualMode && outValid) |-> $past(pixValid));
endmodule

bind dual_tap_stitch tap_stitch_checker uChk (
  .clk(clk), .rstN(rstN), .dualMode(dualMode), .pixValid(pixValid),
  .lineStart(lineStart), .outValid(outValid), .outStart(outStart),
  .lineErr(lineErr)
);

// File: tb/sim_dual_tap_stitch.sv
`timescale 1ns/1ps
module sim_dual_tap_stitch;
  localparam int DW = 12, EP = 2, SP = 3, EB = 1, HA = 4;
  localparam int PRE = EP + SP + EB;
  localparam int LEN_D = PRE + HA;
  localparam int LEN_S = PRE + 2 * HA + EB + SP;

  logic clk = 1'b0, rstN = 1'b0, dualMode = 1'b1, pixValid = 1'b0, lineStart = 1'b0;
  logic [DW-1:0] leftPix = '0, rightPix = '0, outPix;
  logic outValid, outStart, lineErr;

  int checks = 0, failures = 0, cyc = 0;
  int capCnt = 0, errCnt = 0, errCyc = 0;
  int capData [64];
  int capCyc  [64];
  bit capSt   [64];
  int lastDrv [8];
  int startDrv, firstActDrv;

  always #2 clk = ~clk;

  dual_tap_stitch #(.DW(DW), .EMPTY_PIX(EP), .SHIELD_PIX(SP), .EDGE_BUF(EB), .HALF_ACT(HA)) u0 (
    .clk(clk), .rstN(rstN), .dualMode(dualMode), .pixValid(pixValid),
    .lineStart(lineStart), .leftPix(leftPix), .rightPix(rightPix),
    .outValid(outValid), .outStart(outStart), .outPix(outPix), .lineErr(lineErr));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN && outValid && capCnt < 64) begin
      capData[capCnt] = int'(outPix);
      capCyc[capCnt]  = cyc;
      capSt[capCnt]   = outStart;
      capCnt++;
    end
    if (rstN && lineErr) begin
      errCnt++;
      errCyc = cyc;
    end
  end

  function automatic int lv(int n, int p); return n * 256 + p; endfunction
  function automatic int rv(int n, int p); return n * 256 + 128 + p; endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(bit mode);
    @(negedge clk);
    rstN = 1'b0; dualMode = mode; pixValid = 1'b0; lineStart = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    capCnt = 0; errCnt = 0;
  endtask

  task automatic sendLine(int n, int len);
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      pixValid = 1'b1; lineStart = (p == 0);
      leftPix = DW'(lv(n, p)); rightPix = DW'(rv(n, p));
      if (p == 0) startDrv = cyc;
      if (p == PRE) firstActDrv = cyc;
      if (p == len - 1) lastDrv[n % 8] = cyc;
      @(negedge clk);
      pixValid = 1'b0; lineStart = 1'b0;
      leftPix = '1; rightPix = '1;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // dual-mode expected pixel k of row n
  function automatic int expDual(int n, int k);
    if (k < HA) return lv(n, PRE + k);
    return rv(n, PRE + (HA - 1 - (k - HA)));
  endfunction

  task automatic checkDualRow(int base, int n, string req);
    for (int k = 0; k < 2 * HA; k++) begin
      check(capData[base + k] == expDual(n, k), req, capData[base + k], expDual(n, k));
      check(capSt[base + k] == (k == 0), "R4 start flag", int'(capSt[base + k]), int'(k == 0));
      if (k > 0)
        check(capCyc[base + k] == capCyc[base + k - 1] + 1, "R2 consecutive",
              capCyc[base + k], capCyc[base + k - 1] + 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    doReset(1'b1);
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    check(outStart == 1'b0, "R1 outStart", int'(outStart), 0);
    check(lineErr == 1'b0, "R1 lineErr", int'(lineErr), 0);

    // R2 R3 R5: three back-to-back dual rows
    sendLine(1, LEN_D);
    sendLine(2, LEN_D);
    sendLine(3, LEN_D);
    idle(20);
    check(capCnt == 3 * 2 * HA, "R2 pixel count", capCnt, 3 * 2 * HA);
    checkDualRow(0, 1, "R2 R3 row1");
    checkDualRow(2 * HA, 2, "R5 row2");
    checkDualRow(4 * HA, 3, "R5 row3");
    // R4: first pixel two edges after the last sample's capture edge
    check(capCyc[0] == lastDrv[1] + 2, "R4 latency row1", capCyc[0], lastDrv[1] + 2);
    check(capCyc[2 * HA] == lastDrv[2] + 2, "R5 latency row2", capCyc[2 * HA], lastDrv[2] + 2);
    check(errCnt == 0, "R8 no spurious error", errCnt, 0);

    // R8: truncated row, then a full row
    capCnt = 0;
    sendLine(4, LEN_D - 3);
    sendLine(5, LEN_D);
    idle(16);
    check(errCnt == 1, "R8 error count", errCnt, 1);
    check(errCyc == startDrv + 1, "R8 error timing", errCyc, startDrv + 1);
    check(capCnt == 2 * HA, "R8 truncated row dropped", capCnt, 2 * HA);
    checkDualRow(0, 5, "R8 following row");

    // R9: samples after a complete row without start-of-row
    capCnt = 0; errCnt = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); pixValid = 1'b1; lineStart = 1'b0; leftPix = 12'h0AA;
      @(negedge clk); pixValid = 1'b0;
    end
    idle(12);
    check(capCnt == 0, "R9 no output", capCnt, 0);
    check(errCnt == 0, "R9 no error", errCnt, 0);

    // R10: start-of-row with pixValid low is ignored
    for (int i = 0; i < LEN_D + 2; i++) begin
      @(negedge clk); pixValid = 1'b0; lineStart = (i == 0); leftPix = DW'(i); rightPix = DW'(i);
    end
    lineStart = 1'b0;
    idle(12);
    check(capCnt == 0, "R10 no output", capCnt, 0);
    check(errCnt == 0, "R10 no error", errCnt, 0);

    // R6 R7: single mode, right tap carries values that must not appear
    doReset(1'b0);
    sendLine(6, LEN_S);
    check(capCnt == 2 * HA, "R6 single count row6", capCnt, 2 * HA);
    check(capCyc[0] == firstActDrv + 1, "R6 single latency", capCyc[0], firstActDrv + 1);
    sendLine(7, LEN_S);
    idle(6);
    check(capCnt == 4 * HA, "R6 single count", capCnt, 4 * HA);
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 2 * HA; k++) begin
        check(capData[r * 2 * HA + k] == lv(6 + r, PRE + k), "R6 single data",
              capData[r * 2 * HA + k], lv(6 + r, PRE + k));
        check(capSt[r * 2 * HA + k] == (k == 0), "R7 single start",
              int'(capSt[r * 2 * HA + k]), int'(k == 0));
      end
    check(errCnt == 0, "R6 no error", errCnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule